// File: doc/BRIEF.md
# Gated Oscillator Frequency Measurement Counter

This block measures how fast an untrimmed high-speed clock (an RC oscillator, say) runs by counting its cycles over a fixed window timed by a slow, accurate reference clock. The reference drives a free-running time-base counter, and one of its bits serves as a 64 Hz phase signal. After software arms a measurement, the window opens on the next falling edge of that phase signal. It stays open for exactly `GATE_TICKS` reference periods (437 by default). The window is carried into the high-speed domain as a synchronised level. While it is high, the cascaded counter advances once per high-speed cycle.

The counter is built from two `SLICE_W`-bit timer slices. In cascade mode the upper slice takes the carry of the lower slice, forming one double-width counter. In single mode only the lower slice counts. When the window closes, hardware clears the measure bit, the count freezes and a done flag rises. Software then reads the count N1. The oscillator frequency is N1 divided by the window length (437/32768 s at the default settings). Software presets the counter before arming, normally to zero, and a sticky overflow flag reports a wrap during the window.

Top module: `freq_meas_counter`

## Requirements
- R1: After reset, the control value, both counter bytes, both data bytes, done and overflow all read 0.
- R2: Arming opens the count window on the first 1-to-0 transition of time-base bit `PHASE_BIT` that follows. The window stays open for exactly `GATE_TICKS` reference periods, so a reference period of R high-speed periods adds exactly `GATE_TICKS*R` to the counter.
- R3: In cascade mode (`mode16_i`=1), address 1 is the low counter byte and address 2 the high counter byte. The result equals the preset plus the counted cycles, modulo 2^16.
- R4: At the end of the window the measure bit (control bit 2) clears itself, done rises, and the counter holds its value until software writes it.
- R5: Overflow is set when the active counter width wraps during a window. It stays set until the next accepted start, which clears it.
- R6: An accepted start clears done, and done and the measure bit are never 1 at the same time.
- R7: While the measure bit is 1, or the reference side has not yet returned to idle, writes to any register are ignored.
- R8: In single mode (`mode16_i`=0) only the low byte counts, modulo 256. The high counter byte keeps its value, and overflow flags the wrap of the low byte.
- R9: A control write (address 0) starts a measurement only with data bits [2:0] = 3'b100 (measure=1, capture=0, run=0). A write with measure=1 and capture or run set stores measure as 0 and keeps the other two bits.
- R10: Data registers (address 3 low byte, address 4 high byte) read back what was written and are not changed by a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_hs | input | 1 | High-speed clock being measured; clocks the register side |
| clk_ref | input | 1 | Reference clock (32.768 kHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mode16_i | input | 1 | 1: cascade both slices; 0: low slice only |
| wr_en_i | input | 1 | Register write strobe (clk_hs domain) |
| wr_addr_i | input | 3 | Register select: 0 control, 1/2 counter low/high, 3/4 data low/high |
| wr_data_i | input | 8 | Write data |
| ctrl_o | output | 3 | Control value: bit 2 measure, bit 1 capture, bit 0 run |
| cnt_o | output | 16 | Counter, high byte above low byte |
| data_o | output | 16 | Data registers, high byte above low byte |
| done_o | output | 1 | Measurement finished and count frozen |
| ovf_o | output | 1 | Sticky wrap flag for the last measurement |

## Verification
Every cycle, the assertions check the following. The window opens only after a phase falling edge and lasts exactly `GATE_TICKS` reference cycles. Done and measure are never set together. The counter holds whenever it is neither counting nor written. The high byte holds in single mode. Control writes have no effect during a busy period. The scenarios alone show the rest: that the frozen count equals preset plus `GATE_TICKS*R` for several reference ratios, modulo the chosen width; that overflow is set and then cleared by a restart; that writes made during a measurement leave the final result untouched; that an illegal start is stored without arming anything.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_DAT_LO = 3'd3,
    REG_DAT_HI = 3'd4
  } fm_reg_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CAPT = 1;
  localparam int CTRL_MEAS = 2;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_ARM  = 2'd1,
    GS_OPEN = 2'd2,
    GS_HOLD = 2'd3
  } gate_state_e;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/fm_sync2.sv
module fm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/fm_ref_gate.sv
module fm_ref_gate
  import fm_pkg::*;
#(
  parameter int TB_W       = 15,
  parameter int PHASE_BIT  = 8,
  parameter int GATE_TICKS = 437
) (
  input  logic clk,
  input  logic rst_n,
  input  logic meas_i,
  output logic gate_o,
  output logic busy_o
);
  localparam int TICK_W = $clog2(GATE_TICKS + 1);

  logic [TB_W-1:0]   tb_q, tb_n;
  logic              phase_d_q;
  logic              phase_fall;
  gate_state_e       st_q, st_n;
  logic [TICK_W-1:0] tick_q, tick_n;
  logic              gate_q, gate_n, busy_q, busy_n;

  assign phase_fall = phase_d_q & ~tb_q[PHASE_BIT];

  always_comb begin
    tb_n   = tb_q + 1'b1;
    st_n   = st_q;
    tick_n = '0;
    unique case (st_q)
      GS_IDLE: if (meas_i) st_n = GS_ARM;
      GS_ARM: begin
        if (!meas_i)         st_n = GS_IDLE;
        else if (phase_fall) st_n = GS_OPEN;
      end
      GS_OPEN: begin
        tick_n = tick_q + 1'b1;
        if (tick_q == TICK_W'(GATE_TICKS - 1)) st_n = GS_HOLD;
      end
      GS_HOLD: if (!meas_i) st_n = GS_IDLE;
      default: st_n = GS_IDLE;
    endcase
    gate_n = (st_n == GS_OPEN);
    busy_n = (st_n != GS_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q      <= '0;
      phase_d_q <= 1'b0;
      st_q      <= GS_IDLE;
      tick_q    <= '0;
      gate_q    <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      tb_q      <= tb_n;
      phase_d_q <= tb_q[PHASE_BIT];
      st_q      <= st_n;
      tick_q    <= tick_n;
      gate_q    <= gate_n;
      busy_q    <= busy_n;
    end
  end

  assign gate_o = gate_q;
  assign busy_o = busy_q;

  // Window-length checker counter
  logic [TICK_W:0] open_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      open_len_q <= '0;
    else if (gate_q) open_len_q <= open_len_q + 1'b1;
    else             open_len_q <= '0;
  end

  a_r2_open_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(phase_fall));

  a_r2_gate_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_q) |-> open_len_q == (TICK_W + 1)'(GATE_TICKS));
endmodule

// File: rtl/fm_timer_slice.sv
module fm_timer_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_we_i,
  input  logic         dat_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] dat_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_n, dat_q, dat_n;

  always_comb begin
    cnt_n = cnt_q;
    dat_n = dat_q;
    if (cnt_we_i)   cnt_n = wdata_i;
    else if (inc_i) cnt_n = cnt_q + 1'b1;
    if (dat_we_i)   dat_n = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dat_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      dat_q <= dat_n;
    end
  end

  assign cnt_o  = cnt_q;
  assign dat_o  = dat_q;
  assign wrap_o = inc_i & (&cnt_q);
endmodule

// File: rtl/freq_meas_counter.sv
module freq_meas_counter
  import fm_pkg::*;
#(
  parameter int TB_W       = 15,
  parameter int PHASE_BIT  = 8,
  parameter int GATE_TICKS = 437,
  parameter int SLICE_W    = 8
) (
  input  logic               clk_hs,
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               mode16_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_addr_i,
  input  logic [SLICE_W-1:0] wr_data_i,
  output logic [2:0]         ctrl_o,
  output logic [2*SLICE_W-1:0] cnt_o,
  output logic [2*SLICE_W-1:0] data_o,
  output logic               done_o,
  output logic               ovf_o
);
  localparam int N_SLICE = 2;

  logic rst_hs_n, rst_ref_n;
  logic ref_gate, ref_busy, gate_s, ref_busy_s, meas_ref;
  logic gate_d_q;
  logic [2:0] ctrl_q, ctrl_n;
  logic done_q, done_n, ovf_q, ovf_n;
  logic busy, wr_ok, wr_ctrl, start, stop, gate_fall, count_en;
  logic inc_lo, inc_hi, wrap_lo, wrap_hi, ovf_set;
  logic [N_SLICE-1:0] cnt_we, dat_we;
  logic [SLICE_W-1:0] cnt_s [N_SLICE];
  logic [SLICE_W-1:0] dat_s [N_SLICE];

  fm_rst_sync u_rst_hs  (.clk(clk_hs),  .rst_n(rst_n), .rst_sync_n(rst_hs_n));
  fm_rst_sync u_rst_ref (.clk(clk_ref), .rst_n(rst_n), .rst_sync_n(rst_ref_n));

  fm_ref_gate #(.TB_W(TB_W), .PHASE_BIT(PHASE_BIT), .GATE_TICKS(GATE_TICKS)) u_gate (
    .clk(clk_ref), .rst_n(rst_ref_n), .meas_i(meas_ref),
    .gate_o(ref_gate), .busy_o(ref_busy));

  fm_sync2 #(.W(2)) u_to_hs (
    .clk(clk_hs), .rst_n(rst_hs_n),
    .d_i({ref_busy, ref_gate}), .q_o({ref_busy_s, gate_s}));

  fm_sync2 #(.W(1)) u_to_ref (
    .clk(clk_ref), .rst_n(rst_ref_n),
    .d_i(ctrl_q[CTRL_MEAS]), .q_o(meas_ref));

  // Register-side control
  always_comb begin
    busy      = ctrl_q[CTRL_MEAS] | ref_busy_s;
    wr_ok     = wr_en_i & ~busy;
    wr_ctrl   = wr_ok & (wr_addr_i == REG_CTRL);
    start     = wr_ctrl & (wr_data_i[2:0] == 3'b100);
    gate_fall = gate_d_q & ~gate_s;
    stop      = gate_fall & ctrl_q[CTRL_MEAS];
    count_en  = gate_s & ctrl_q[CTRL_MEAS];
    inc_lo    = count_en;
    inc_hi    = count_en & mode16_i & wrap_lo;
    ovf_set   = mode16_i ? wrap_hi : wrap_lo;
    cnt_we    = {wr_ok & (wr_addr_i == REG_CNT_HI), wr_ok & (wr_addr_i == REG_CNT_LO)};
    dat_we    = {wr_ok & (wr_addr_i == REG_DAT_HI), wr_ok & (wr_addr_i == REG_DAT_LO)};

    ctrl_n = ctrl_q;
    done_n = done_q;
    ovf_n  = ovf_q;
    if (wr_ctrl) ctrl_n = {start, wr_data_i[CTRL_CAPT], wr_data_i[CTRL_RUN]};
    else if (stop) ctrl_n[CTRL_MEAS] = 1'b0;
    if (start)      done_n = 1'b0;
    else if (stop)  done_n = 1'b1;
    if (start)        ovf_n = 1'b0;
    else if (ovf_set) ovf_n = 1'b1;
  end

  always_ff @(posedge clk_hs or negedge rst_hs_n) begin
    if (!rst_hs_n) begin
      ctrl_q   <= '0;
      done_q   <= 1'b0;
      ovf_q    <= 1'b0;
      gate_d_q <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_n;
      done_q   <= done_n;
      ovf_q    <= ovf_n;
      gate_d_q <= gate_s;
    end
  end

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    logic slc_inc, slc_wrap;
    if (g == 0) begin : g_lo
      assign slc_inc = inc_lo;
      assign wrap_lo = slc_wrap;
    end else begin : g_hi
      assign slc_inc = inc_hi;
      assign wrap_hi = slc_wrap;
    end
    fm_timer_slice #(.W(SLICE_W)) u_slice (
      .clk(clk_hs), .rst_n(rst_hs_n),
      .cnt_we_i(cnt_we[g]), .dat_we_i(dat_we[g]), .wdata_i(wr_data_i),
      .inc_i(slc_inc), .cnt_o(cnt_s[g]), .dat_o(dat_s[g]), .wrap_o(slc_wrap));
  end

  assign ctrl_o = ctrl_q;
  assign cnt_o  = {cnt_s[1], cnt_s[0]};
  assign data_o = {dat_s[1], dat_s[0]};
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  a_r6_done_excl: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
    !(done_q && ctrl_q[CTRL_MEAS]));

  a_r4_frozen: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
    (!count_en && !cnt_we[0]) |=> $stable(cnt_o[SLICE_W-1:0]));

  a_r8_hi_hold: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
    (!mode16_i && !cnt_we[1]) |=> $stable(cnt_o[2*SLICE_W-1:SLICE_W]));

  a_r7_busy_ctrl: assert property (@(posedge clk_hs) disable iff (!rst_hs_n)
    (wr_en_i && wr_addr_i == REG_CTRL && ctrl_o[CTRL_MEAS]) |=> $stable(ctrl_o[1:0]));
endmodule

// File: tb/test_freq_meas_counter.sv
`timescale 1ns/1ps
module test_freq_meas_counter;
  localparam int GT = 437;

  logic        clk_hs = 1'b0;
  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        mode16;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [2:0]  ctrl_o;
  logic [15:0] cnt_o, data_o;
  logic        done_o, ovf_o;

  int checks = 0;
  int errors = 0;
  int ref_half = 8;
  bit finished = 0;

  freq_meas_counter i_freq_meas_counter (
    .clk_hs(clk_hs), .clk_ref(clk_ref), .rst_n(rst_n), .mode16_i(mode16),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ctrl_o(ctrl_o), .cnt_o(cnt_o), .data_o(data_o), .done_o(done_o), .ovf_o(ovf_o));

  always #2 clk_hs = ~clk_hs;
  initial begin
    #1;
    forever #(ref_half) clk_ref = ~clk_ref;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_hs);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_hs);
    wr_en = 1'b0;
  endtask

  function automatic logic [16:0] expect_sum(input logic [15:0] preset, input int r, input bit m16);
    int total;
    total = (m16 ? int'(preset) : int'(preset[7:0])) + GT * r;
    if (m16) return {total > 65535, 16'(total)};
    else     return {total > 255, preset[15:8], 8'(total)};
  endfunction

  task automatic run_meas(input int r, input logic [15:0] preset, input bit m16, input bit poke);
    logic [16:0] e;
    logic [15:0] frozen;
    int n;
    ref_half = 2 * r;
    repeat (8 * r + 10) @(negedge clk_hs);
    mode16 = m16;
    wr(3'd1, preset[7:0]);
    wr(3'd2, preset[15:8]);
    wr(3'd0, 8'h04);
    chk(ctrl_o == 3'b100, "R4", "measure bit set on start", ctrl_o, 3'b100);
    chk(done_o == 1'b0, "R6", "done cleared on start", done_o, 0);
    chk(ovf_o == 1'b0, "R5", "overflow cleared on start", ovf_o, 0);
    if (poke) begin
      wr(3'd0, 8'h03);
      wr(3'd1, 8'h5A);
      wr(3'd4, 8'hEE);
      chk(ctrl_o == 3'b100, "R7", "control write ignored while busy", ctrl_o, 3'b100);
    end
    n = 0;
    while (!done_o && n < 40000) begin
      @(negedge clk_hs);
      n++;
    end
    e = expect_sum(preset, r, m16);
    chk(done_o == 1'b1, "R4", "done after window", done_o, 1);
    chk(cnt_o == e[15:0], m16 ? "R2 R3" : "R2 R8", "frozen count", cnt_o, e[15:0]);
    chk(ovf_o == e[16], m16 ? "R5" : "R8", "overflow flag", ovf_o, e[16]);
    chk(ctrl_o == 3'b000, "R4", "measure bit self-cleared", ctrl_o, 0);
    frozen = cnt_o;
    repeat (60) @(negedge clk_hs);
    chk(cnt_o == frozen, "R4", "count holds after stop", cnt_o, frozen);
    repeat (12 * r + 20) @(negedge clk_hs);
  endtask

  initial begin
    logic [15:0] pre;
    int r;
    void'($urandom(32'd2718));
    rst_n = 1'b0; mode16 = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (5) @(negedge clk_hs);
    rst_n = 1'b1;
    repeat (30) @(negedge clk_hs);
    chk(ctrl_o == 0, "R1", "reset control", ctrl_o, 0);
    chk(cnt_o == 0, "R1", "reset counter", cnt_o, 0);
    chk(data_o == 0, "R1", "reset data", data_o, 0);
    chk(done_o == 0 && ovf_o == 0, "R1", "reset flags", {done_o, ovf_o}, 0);

    wr(3'd3, 8'h3C);
    wr(3'd4, 8'hA5);
    chk(data_o == 16'hA53C, "R10", "data readback", data_o, 16'hA53C);

    // illegal start: measure with run set
    wr(3'd0, 8'h05);
    chk(ctrl_o == 3'b001, "R9", "illegal start stored without measure", ctrl_o, 3'b001);
    repeat (3000) @(negedge clk_hs);
    chk(cnt_o == 0 && done_o == 0, "R9", "no count after illegal start", cnt_o, 0);
    wr(3'd0, 8'h00);

    run_meas(4, 16'h0000, 1'b1, 1'b1);
    chk(data_o == 16'hA53C, "R10", "data untouched by measurement and busy write", data_o, 16'hA53C);
    chk(data_o[15:8] == 8'hA5, "R7", "busy data write ignored", data_o[15:8], 8'hA5);

    run_meas(6, 16'hF800, 1'b1, 1'b0);   // 16-bit wrap
    run_meas(3, 16'h0010, 1'b1, 1'b0);   // restart clears overflow
    run_meas(2, 16'h7C20, 1'b0, 1'b0);   // single mode, high byte held

    for (int k = 0; k < 3; k++) begin
      r = 2 + int'($urandom_range(8));
      pre = 16'($urandom_range(16'hFFFF));
      run_meas(r, pre, k != 1, 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk_hs);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule